// File: doc/BRIEF.md
# Cascadable Post-Scale Clock Divider Bank

This block holds a bank of post-scale divide counters that share one fast source clock. Each stage produces an output clock whose period and duty cycle come from two separate counts. The high count sets how many input events the output stays high. The low count sets how many it stays low. The division ratio is the sum of the two counts. A per-stage half-step flag moves the falling edge of the output half a source period later. This gives the duty cycle a resolution of half a source cycle.

Any stage other than the first can count the rising edges of the previous stage's output instead of source cycles. A chained pair then divides by the product of the two ratios, which reaches ratios beyond what a single stage can give. A bypass bit passes a stage's input clock straight through. All counters run in the source-clock domain. Chaining is done with a one-cycle event pulse from the previous stage, not with a derived clock. New counts are picked up only when a high phase begins, so a change in settings never produces a runt pulse.

Top module: `pscd_bank`

## Requirements
- R1: While `rst_n` is low, every non-bypassed output is low. After `rst_n` is sampled high, each source-mode stage starts its first high phase on the next source rising edge.
- R2: A source-mode stage with high count H and low count L (each 1..255) outputs a clock that is high for H source cycles and has a period of H+L source cycles.
- R3: A high or low count of 0 stands for 256. The largest single-stage ratio is therefore 512.
- R4: With the half-step flag set on a source-mode stage, the high time is H+0.5 source cycles and the period stays H+L.
- R5: When `casc_sel[n]` is 1 (n ≥ 1), stage n counts rising edges of stage n-1's output. Its period is (Hn+Ln) times stage n-1's period, and its high time is Hn times that period. Its rising edge falls on the same source edge as a rising edge of stage n-1.
- R6: The half-step flag has no effect on a stage in cascade mode.
- R7: `casc_sel[0]` has no effect. Stage 0 always counts source cycles, including its half-step behaviour.
- R8: With `bypass[n]` set, output n equals the stage's input clock: the source clock, or output n-1 when cascaded. It also passes that input's rising-edge events on to stage n+1.
- R9: Counts and the half-step flag are latched only when a high phase begins. A change in the middle of a period leaves that period's high and low times unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cnt | input | NUM_STAGES*CNT_W | High-time count per stage, stage n in bits [n*CNT_W +: CNT_W], 0 means 256 |
| lo_cnt | input | NUM_STAGES*CNT_W | Low-time count per stage, same packing, 0 means 256 |
| half_en | input | NUM_STAGES | Half-step flag per stage: extends the high phase by half a source cycle |
| casc_sel | input | NUM_STAGES | Cascade select per stage: bit n set makes stage n count stage n-1 output edges |
| bypass | input | NUM_STAGES | Bypass per stage: output equals the stage input clock |
| clk_out | output | NUM_STAGES | Divided output clocks |

## Verification
The bench measures every output on a half-cycle grid, so an off-by-one in either count, or a half step applied to the wrong edge, shows up directly as a wrong high or period length. It sweeps one stage over every split of a divide-by-10 period, with and without the half step. It also targets these cases:
- Zero counts. A design that took 0 literally would stall or give a one-cycle phase.
- Chained stages. A design that clocked a cascaded stage from the source would show the single-stage ratio instead of the product.
- The half step on a cascaded stage, and the cascade select on stage 0. A design that obeyed either would show a shifted edge or a multiplied period.
- A mid-period change of counts. A design that took the new value at once would cut the high or low phase short.

// File: rtl/pscd_pkg.sv
// Shared types for the post-scale divider bank.
package pscd_pkg;

    // Output phase of one divide counter.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/pscd_count_core.sv
// Divide counter core for one stage.
// Counts input events (tick) in the source-clock domain. The stage stays high
// for the latched high count and low for the latched low count. A count of 0
// wraps so that it means 2**CNT_W.
// Assumes: tick is a one-cycle-wide qualifier synchronous to clk. Settings are
// sampled only at the start of a high phase.
module pscd_count_core
    import pscd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_set,
    input  logic [CNT_W-1:0] lo_set,
    input  logic             half_set,
    output logic             div_q,
    output logic             rise,
    output logic             half_lat,
    output logic [CNT_W-1:0] hi_lat
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           phase;
    logic             fresh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo_lat;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] lo_last;
    logic             start_hi;
    logic             end_hi;

    // Terminal values; a zero count wraps to all ones, giving 2**CNT_W events.
    assign hi_last = hi_lat - ONE;
    assign lo_last = lo_lat - ONE;

    // A high phase starts from low, on the first event after reset or when the low count runs out.
    assign start_hi = rst_n && tick && (phase == PH_LOW) && (fresh || (cnt == lo_last));

    // A high phase ends when the high count runs out.
    assign end_hi = tick && (phase == PH_HIGH) && (cnt == hi_last);

    // Phase, count and latched settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_LOW;
            fresh    <= 1'b1;
            cnt      <= '0;
            hi_lat   <= '0;
            lo_lat   <= '0;
            half_lat <= 1'b0;
        end else if (start_hi) begin
            phase    <= PH_HIGH;
            fresh    <= 1'b0;
            cnt      <= '0;
            hi_lat   <= hi_set;
            lo_lat   <= lo_set;
            half_lat <= half_set;
        end else if (end_hi) begin
            phase <= PH_LOW;
            cnt   <= '0;
        end else if (tick) begin
            cnt <= cnt + ONE;
        end
    end

    assign div_q = (phase == PH_HIGH);
    assign rise  = start_hi;

endmodule

// File: rtl/pscd_half_ext.sv
// Half-cycle extender.
// A falling-edge register follows the divided output, so that when enabled
// the high phase lasts half a source period longer.
// Assumes: div_q comes from a rising-edge register on the same clk, and every
// low phase lasts at least one source cycle.
module pscd_half_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic div_q,
    output logic ext_out
);

    logic trail_q;

    // Falling-edge copy of the divided output.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            trail_q <= 1'b0;
        end else begin
            trail_q <= div_q;
        end
    end

    // The copy only lengthens a high phase; it never starts one.
    assign ext_out = div_q | (en & trail_q);

endmodule

// File: rtl/pscd_out_sel.sv
// Output selector for one stage.
// In bypass, the stage's input clock and its event pulse pass straight through.
// Otherwise the divided clock and the stage's own high-start pulse go out.
// Assumes: in_clk and tick belong to the same input (source or previous stage).
module pscd_out_sel (
    input  logic bypass,
    input  logic in_clk,
    input  logic tick,
    input  logic div_out,
    input  logic rise_core,
    output logic clk_o,
    output logic rise_o
);

    // Clock and event forwarding.
    always_comb begin
        if (bypass) begin
            clk_o  = in_clk;
            rise_o = tick;
        end else begin
            clk_o  = div_out;
            rise_o = rise_core;
        end
    end

endmodule

// File: rtl/pscd_bank.sv
// Cascadable post-scale divider bank (top).
// NUM_STAGES counters share the source clock. A stage n >= 1 may count rising-edge
// events of stage n-1 instead of source cycles, so that the ratios multiply.
// Assumes: every counter runs on clk; cascading uses a one-cycle event pulse,
// not a derived clock. The half step applies only to stages fed by the source.
module pscd_bank #(
    parameter int NUM_STAGES = 5,
    parameter int CNT_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_STAGES*CNT_W-1:0] hi_cnt,
    input  logic [NUM_STAGES*CNT_W-1:0] lo_cnt,
    input  logic [NUM_STAGES-1:0]       half_en,
    input  logic [NUM_STAGES-1:0]       casc_sel,
    input  logic [NUM_STAGES-1:0]       bypass,
    output logic [NUM_STAGES-1:0]       clk_out
);

    logic                        stage_tick [NUM_STAGES];
    logic                        stage_inclk[NUM_STAGES];
    logic                        stage_rise [NUM_STAGES];
    logic                        stage_clk  [NUM_STAGES];
    logic                        use_casc   [NUM_STAGES];
    logic [NUM_STAGES-1:0]       div_vec;
    logic [NUM_STAGES-1:0]       core_rise_vec;
    logic [NUM_STAGES-1:0]       rise_vec;
    logic [NUM_STAGES*CNT_W-1:0] hi_lat_flat;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic             div_q;
        logic             rise_core;
        logic             half_lat;
        logic             div_ext;
        logic [CNT_W-1:0] hi_lat;

        // Input selection: stage 0 is always fed by the source.
        if (i == 0) begin : g_first
            assign use_casc[i]    = 1'b0;
            assign stage_tick[i]  = 1'b1;
            assign stage_inclk[i] = clk;
        end else begin : g_chain
            assign use_casc[i]    = casc_sel[i];
            assign stage_tick[i]  = casc_sel[i] ? stage_rise[i-1] : 1'b1;
            assign stage_inclk[i] = casc_sel[i] ? stage_clk[i-1] : clk;
        end

        pscd_count_core #(
            .CNT_W(CNT_W)
        ) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (stage_tick[i]),
            .hi_set  (hi_cnt[i*CNT_W +: CNT_W]),
            .lo_set  (lo_cnt[i*CNT_W +: CNT_W]),
            .half_set(half_en[i]),
            .div_q   (div_q),
            .rise    (rise_core),
            .half_lat(half_lat),
            .hi_lat  (hi_lat)
        );

        pscd_half_ext u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (half_lat & ~use_casc[i]),
            .div_q  (div_q),
            .ext_out(div_ext)
        );

        pscd_out_sel u_sel (
            .bypass   (bypass[i]),
            .in_clk   (stage_inclk[i]),
            .tick     (stage_tick[i]),
            .div_out  (div_ext),
            .rise_core(rise_core),
            .clk_o    (stage_clk[i]),
            .rise_o   (stage_rise[i])
        );

        // Flat views for the ports and the bound checker.
        assign clk_out[i]                    = stage_clk[i];
        assign div_vec[i]                    = div_q;
        assign core_rise_vec[i]              = rise_core;
        assign rise_vec[i]                   = stage_rise[i];
        assign hi_lat_flat[i*CNT_W +: CNT_W] = hi_lat;
    end

endmodule

// File: rtl/pscd_bank_chk.sv
// Property checker for pscd_bank, attached by bind.
// Assumes: it sees the per-stage divided phase, core high-start pulses,
// forwarded event pulses and latched high counts of the bank.
module pscd_bank_chk #(
    parameter int NUM_STAGES = 5,
    parameter int CNT_W      = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_STAGES-1:0]       casc_sel,
    input logic [NUM_STAGES-1:0]       div_vec,
    input logic [NUM_STAGES-1:0]       core_rise_vec,
    input logic [NUM_STAGES-1:0]       rise_vec,
    input logic [NUM_STAGES*CNT_W-1:0] hi_lat_flat
);

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_chk
        // R2: a high phase only begins from the low phase.
        p_start_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            core_rise_vec[i] |-> !div_vec[i]);

        // R2: a high-start pulse is followed by a high divided phase.
        p_rise_goes_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            core_rise_vec[i] |=> div_vec[i]);

        // R9: latched high count changes only at a high start.
        p_hold_settings_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !core_rise_vec[i] |=> $stable(hi_lat_flat[i*CNT_W +: CNT_W]));

        if (i > 0) begin : g_chain
            // R5: a cascaded stage starts high only on an event of the previous stage.
            p_chain_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (casc_sel[i] && core_rise_vec[i]) |-> rise_vec[i-1]);
        end
    end

endmodule

bind pscd_bank pscd_bank_chk #(
    .NUM_STAGES(NUM_STAGES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .casc_sel     (casc_sel),
    .div_vec      (div_vec),
    .core_rise_vec(core_rise_vec),
    .rise_vec     (rise_vec),
    .hi_lat_flat  (hi_lat_flat)
);

// File: tb/sim_pscd_bank.sv
// Bench for pscd_bank. It measures every output in half source cycles and
// compares against arithmetic expectations.
module sim_pscd_bank;

    localparam int N   = 5;
    localparam int W   = 8;
    localparam int LIM = 6000;

    logic           clk;
    logic           rst_n;
    logic [N*W-1:0] hi_cnt;
    logic [N*W-1:0] lo_cnt;
    logic [N-1:0]   half_en;
    logic [N-1:0]   casc_sel;
    logic [N-1:0]   bypass;
    logic [N-1:0]   clk_out;

    int errors = 0;
    int checks = 0;

    pscd_bank #(.NUM_STAGES(N), .CNT_W(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .half_en (half_en),
        .casc_sel(casc_sel),
        .bypass  (bypass),
        .clk_out (clk_out)
    );

    // 125 MHz source clock.
    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int span(input int v);
        return (v == 0) ? 256 : v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_cfg();
        hi_cnt   = '0;
        lo_cnt   = '0;
        half_en  = '0;
        casc_sel = '0;
        bypass   = '0;
        for (int i = 0; i < N; i++) begin
            hi_cnt[i*W +: W] = 8'd1;
            lo_cnt[i*W +: W] = 8'd1;
        end
    endtask

    task automatic set_stage(input int i, input int h, input int l, input bit hf,
                             input bit cs, input bit bp);
        hi_cnt[i*W +: W] = W'(h);
        lo_cnt[i*W +: W] = W'(l);
        half_en[i]       = hf;
        casc_sel[i]      = cs;
        bypass[i]        = bp;
    endtask

    // Reset pulse; ends on the sampling grid (1 ns after a rising edge).
    task automatic do_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Advance on the half-cycle grid until the output shows a rising edge.
    task automatic wait_rise(input int idx, output bit ok);
        bit prev;
        bit cur;
        prev = clk_out[idx];
        ok   = 1'b0;
        for (int k = 0; k < LIM; k++) begin
            #4;
            cur = clk_out[idx];
            if (!prev && cur) begin
                ok = 1'b1;
                break;
            end
            prev = cur;
        end
    endtask

    // Starting at a rising-edge sample, count high and period length in halves.
    task automatic count_period(input int idx, output int hi, output int per);
        bit seen_low;
        bit cur;
        hi       = 1;
        per      = 1;
        seen_low = 1'b0;
        for (int k = 0; k < LIM; k++) begin
            #4;
            cur = clk_out[idx];
            if (!seen_low) begin
                if (cur) begin
                    hi++;
                end else begin
                    seen_low = 1'b1;
                end
                per++;
            end else begin
                if (cur) break;
                per++;
            end
        end
    endtask

    // Measure the second full period of one output and check it.
    task automatic measure(input int idx, input int exp_hi, input int exp_per, input string req);
        bit ok;
        int hi;
        int per;
        wait_rise(idx, ok);
        if (!ok) begin
            chk(req, $sformatf("out%0d rising edge seen", idx), 0, 1);
            return;
        end
        count_period(idx, hi, per);
        count_period(idx, hi, per);
        chk(req, $sformatf("out%0d high halves", idx), hi, exp_hi);
        chk(req, $sformatf("out%0d period halves", idx), per, exp_per);
    endtask

    initial begin
        bit ok;
        int hi;
        int per;
        rst_n = 1'b1;
        clear_cfg();

        // R1: outputs low in reset; first high phase one source edge after release.
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "outputs during reset", int'(clk_out), 0);
        rst_n = 1'b1;
        #4;
        chk("R1", "out0 before first edge after release", int'(clk_out[0]), 0);
        #4;
        chk("R1", "out0 after first edge after release", int'(clk_out[0]), 1);

        // R2, R4: independent source-mode stages with mixed settings.
        clear_cfg();
        set_stage(0, 1, 1, 0, 0, 0);
        set_stage(1, 3, 2, 0, 0, 0);
        set_stage(2, 2, 3, 1, 0, 0);
        set_stage(3, 5, 5, 0, 0, 0);
        set_stage(4, 1, 9, 0, 0, 0);
        do_reset();
        measure(0, 2, 4, "R2");
        measure(1, 6, 10, "R2");
        measure(2, 5, 10, "R4");
        measure(3, 10, 20, "R2");
        measure(4, 2, 20, "R2");

        // R2, R4: sweep every high/low split of a divide-by-10 stage, with and without the half step.
        for (int h = 1; h <= 9; h++) begin
            for (int hf = 0; hf <= 1; hf++) begin
                clear_cfg();
                set_stage(3, h, 10 - h, hf[0], 0, 0);
                do_reset();
                measure(3, 2 * h + hf, 20, (hf != 0) ? "R4" : "R2");
            end
        end

        // R3: zero counts stand for 256.
        clear_cfg();
        set_stage(3, 0, 2, 0, 0, 0);
        set_stage(4, 2, 0, 0, 0, 0);
        do_reset();
        measure(3, 2 * span(0), 2 * (span(0) + 2), "R3");
        measure(4, 4, 2 * (2 + span(0)), "R3");

        // R5, R6: chain of three stages; half step on the cascaded stage is ignored.
        clear_cfg();
        set_stage(0, 2, 2, 0, 0, 0);
        set_stage(1, 1, 1, 0, 1, 0);
        set_stage(2, 1, 2, 1, 1, 0);
        do_reset();
        measure(1, 2 * 1 * 4, 2 * 2 * 4, "R5");
        wait_rise(1, ok);
        chk("R5", "out0 high at out1 rising edge", int'(ok && clk_out[0]), 1);
        measure(2, 2 * 1 * 8, 2 * 3 * 8, "R6");

        // R7: cascade select on stage 0 ignored; its half step still applies.
        clear_cfg();
        set_stage(0, 3, 1, 1, 1, 0);
        do_reset();
        measure(0, 7, 8, "R7");

        // R8: bypass of a source stage and of a cascaded stage.
        clear_cfg();
        set_stage(0, 1, 1, 0, 0, 1);
        do_reset();
        measure(0, 1, 2, "R8");
        clear_cfg();
        set_stage(0, 1, 3, 0, 0, 0);
        set_stage(1, 5, 5, 0, 1, 1);
        set_stage(2, 1, 1, 0, 1, 0);
        do_reset();
        measure(1, 2, 8, "R8");
        measure(2, 8, 16, "R8");

        // R9: settings changed at a high start apply only to the next period.
        clear_cfg();
        set_stage(0, 4, 4, 0, 0, 0);
        do_reset();
        wait_rise(0, ok);
        wait_rise(0, ok);
        set_stage(0, 1, 1, 0, 0, 0);
        count_period(0, hi, per);
        chk("R9", "high halves of current period", hi, 8);
        chk("R9", "current period halves", per, 16);
        count_period(0, hi, per);
        chk("R9", "high halves of next period", hi, 2);
        chk("R9", "next period halves", per, 4);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule